// File: doc/BRIEF.md
# Endpoint FIFO with Early Full/Empty Flags

This block is a single-clock FIFO that sits on an endpoint data path between a packet engine and an external synchronous master. It stores bytes in a memory of `CAP_BYTES` entries. It has one write port and one read port, and it reports its occupancy in entries together with registered full and empty flags. The clock may come from inside the chip or from the attached master. Either way, all state moves on that one edge.

Two configuration inputs let a flag come up one entry ahead of the true condition. A simple master that samples the flag a cycle late therefore never overruns or underruns the FIFO. The early-full option only has an effect on an IN-direction instance. The early-empty option only has an effect on an OUT-direction instance. The direction is an elaboration parameter. A width input selects byte or 16-bit transfers. The block also reports whether the upper byte lane of the shared data bus is needed: that is the case when this endpoint or any peer endpoint runs 16-bit.

Top module: `epfifo_early`

## Requirements
- R1: After reset, `empty_flag` is 1, `full_flag` is 0 and `level` is 0.
- R2: Data leaves in write order. `rd_data` always shows the oldest stored entry without a read strobe. In byte mode only `wr_data[7:0]` is stored, and `rd_data[15:8]` reads 0.
- R3: `level` counts stored entries. An accepted write adds one and an accepted read removes one. When both are accepted in the same cycle, `level` is unchanged.
- R4: A write is ignored while `level` equals the capacity in entries, even when a read happens in the same cycle. With early-full off, `full_flag` is 1 exactly when `level` equals the capacity.
- R5: A read is ignored while `level` is 0, and `level` stays 0.
- R6: On an IN instance with `cfg_full_m1`=1, `full_flag` is 1 whenever `level` is at least the capacity minus one. A write at capacity minus one is still accepted.
- R7: On an OUT instance with `cfg_empty_p1`=1, `empty_flag` is 1 whenever `level` is at most 1. A read at level 1 is still accepted. With the option off, `empty_flag` is 1 exactly when `level` is 0.
- R8: `cfg_empty_p1` has no effect on an IN instance, and `cfg_full_m1` has no effect on an OUT instance.
- R9: With `cfg_wide`=1, each access moves 16 bits. `wr_data[7:0]` is the earlier byte, and `rd_data` returns both bytes in the same lanes. Capacity becomes `CAP_BYTES/2` entries. `cfg_wide` may change only while the FIFO is empty.
- R10: `hi_lane_en` is the OR of `cfg_wide` and every bit of `peer_wide`, with no clock delay.
- R11: The flags are registers. They reflect an access, or a change of an early option, on the first clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single FIFO clock, internal or external |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1 selects 16-bit entries, 0 selects bytes |
| cfg_full_m1 | input | 1 | Early full option (IN instance only) |
| cfg_empty_p1 | input | 1 | Early empty option (OUT instance only) |
| peer_wide | input | N_PEER | Width selects of the other endpoints |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 2*BYTE_W | Write data, earlier byte in the low lane |
| rd_en | input | 1 | Read strobe (pops the shown entry) |
| rd_data | output | 2*BYTE_W | Oldest stored entry |
| full_flag | output | 1 | Registered full indication |
| empty_flag | output | 1 | Registered empty indication |
| level | output | $clog2(CAP_BYTES)+1 | Occupancy in entries |
| hi_lane_en | output | 1 | Upper byte lane in use |

## Verification
The bench fills the FIFO to its limit and pushes one more write, with and without a read in the same cycle. A design that let the write through would lose or corrupt the oldest data and step `level` past the capacity. It toggles the early options at the threshold entries. A design that used the early flag to block access would refuse the legal write at capacity minus one or the legal read at level one. A design that ignored the direction parameter would raise a flag early on the wrong instance. In 16-bit mode it checks byte-lane order and the halved capacity, which a design counting bytes as entries would get wrong. Reading while empty must leave `level` at 0 rather than wrapping.

// File: rtl/epf_pkg.sv
package epf_pkg;

   // Convert a byte count into an entry count for the selected width.
   function automatic logic [31:0] to_entries(input logic [31:0] nbytes, input logic wide);
      return wide ? (nbytes >> 1) : nbytes;
   endfunction

endpackage

// File: rtl/epf_store.sv
module epf_store #(
   parameter int AW     = 9,
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                we,
   input  logic                wide,
   input  logic [AW-1:0]       wptr,
   input  logic [2*BYTE_W-1:0] wdata,
   input  logic [AW-1:0]       rptr,
   output logic [2*BYTE_W-1:0] rdata
);
   localparam int NB = 1 << AW;

   logic [BYTE_W-1:0] mem [NB];
   logic [AW-1:0]     wp1;
   logic [AW-1:0]     rp1;

   assign wp1 = wptr + 1'b1;
   assign rp1 = rptr + 1'b1;

   always_ff @(posedge clk) begin
      if (we) begin
         mem[wptr] <= wdata[BYTE_W-1:0];
         if (wide) mem[wp1] <= wdata[2*BYTE_W-1:BYTE_W];
      end
   end

   always_comb begin
      if (wide) rdata = {mem[rp1], mem[rptr]};
      else      rdata = {{BYTE_W{1'b0}}, mem[rptr]};
   end
endmodule

// File: rtl/epf_ctrl.sv
module epf_ctrl
   import epf_pkg::*;
#(
   parameter int AW    = 9,
   parameter bit IS_IN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wide,
   input  logic          fm1,
   input  logic          ep1,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic          we,
   output logic [AW-1:0] wptr,
   output logic [AW-1:0] rptr,
   output logic [AW:0]   level,
   output logic          full_flag,
   output logic          empty_flag
);
   localparam int          CAP  = 1 << AW;
   localparam logic [AW:0] CAPV = (AW+1)'(CAP);

   logic [AW:0] cnt, cnt_nx, step, cap_ent, ent_nx;
   logic        true_full, true_empty, wr_ok, rd_ok;
   logic        full_early, empty_early, full_nx, empty_nx;

   // Direction decides which early option is honoured.
   generate
      if (IS_IN) begin : g_in
         assign full_early  = fm1;
         assign empty_early = 1'b0;
      end else begin : g_out
         assign full_early  = 1'b0;
         assign empty_early = ep1;
      end
   endgenerate

   assign step       = wide ? (AW+1)'(2) : (AW+1)'(1);
   assign cap_ent    = wide ? (CAPV >> 1) : CAPV;
   assign level      = (AW+1)'(to_entries(32'(cnt), wide));
   assign true_full  = (level == cap_ent);
   assign true_empty = (cnt == '0);
   assign wr_ok      = wr_en && !true_full;
   assign rd_ok      = rd_en && !true_empty;
   assign we         = wr_ok;

   always_comb begin
      cnt_nx = cnt;
      if (wr_ok) cnt_nx = cnt_nx + step;
      if (rd_ok) cnt_nx = cnt_nx - step;
      ent_nx   = (AW+1)'(to_entries(32'(cnt_nx), wide));
      full_nx  = full_early  ? (ent_nx >= cap_ent - 1'b1) : (ent_nx == cap_ent);
      empty_nx = empty_early ? (ent_nx <= (AW+1)'(1))   : (ent_nx == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt        <= '0;
         wptr       <= '0;
         rptr       <= '0;
         full_flag  <= 1'b0;
         empty_flag <= 1'b1;
      end else begin
         cnt        <= cnt_nx;
         if (wr_ok) wptr <= wptr + step[AW-1:0];
         if (rd_ok) rptr <= rptr + step[AW-1:0];
         full_flag  <= full_nx;
         empty_flag <= empty_nx;
      end
   end

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CAPV);

   // R4
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && true_full && !rd_en) |=> cnt == $past(cnt));

   // R5
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && true_empty && !wr_en) |=> cnt == '0);

   // R4
   true_full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(full_early) |-> (full_flag == (level == cap_ent)));

   // R7
   true_empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(empty_early) |-> (empty_flag == (cnt == '0)));

   // R9
   wide_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wide != $past(wide)) |-> $past(cnt) == '0);
endmodule

// File: rtl/epfifo_early.sv
module epfifo_early #(
   parameter int CAP_BYTES = 512,
   parameter int BYTE_W    = 8,
   parameter int N_PEER    = 3,
   parameter bit IS_IN     = 1'b1,
   localparam int AW       = $clog2(CAP_BYTES),
   localparam int DW       = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wide,
   input  logic              cfg_full_m1,
   input  logic              cfg_empty_p1,
   input  logic [N_PEER-1:0] peer_wide,
   input  logic              wr_en,
   input  logic [DW-1:0]     wr_data,
   input  logic              rd_en,
   output logic [DW-1:0]     rd_data,
   output logic              full_flag,
   output logic              empty_flag,
   output logic [AW:0]       level,
   output logic              hi_lane_en
);
   initial begin
      cap_pow2_chk: assert ((1 << AW) == CAP_BYTES && CAP_BYTES >= 4)
         else $fatal(1, "CAP_BYTES must be a power of two, at least 4");
      byte_w_chk: assert (BYTE_W >= 1)
         else $fatal(1, "BYTE_W must be positive");
   end

   logic          we;
   logic [AW-1:0] wptr, rptr;

   assign hi_lane_en = cfg_wide | (|peer_wide);

   epf_ctrl #(.AW(AW), .IS_IN(IS_IN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wide(cfg_wide), .fm1(cfg_full_m1),
      .ep1(cfg_empty_p1), .wr_en(wr_en), .rd_en(rd_en), .we(we),
      .wptr(wptr), .rptr(rptr), .level(level),
      .full_flag(full_flag), .empty_flag(empty_flag)
   );

   epf_store #(.AW(AW), .BYTE_W(BYTE_W)) u_store (
      .clk(clk), .we(we), .wide(cfg_wide), .wptr(wptr), .wdata(wr_data),
      .rptr(rptr), .rdata(rd_data)
   );

   // R10
   hi_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wide |-> hi_lane_en);
endmodule

// File: tb/sim_epfifo_early.sv
module sim_epfifo_early;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // u0: IN instance, byte mode
   logic a_fm1 = 0, a_ep1 = 0, a_wr = 0, a_rd = 0;
   logic [2:0]  a_peer = '0;
   logic [15:0] a_din = '0, a_dout;
   logic        a_full, a_empty, a_hi;
   logic [3:0]  a_lvl;
   // u1: OUT instance, 16-bit mode
   logic b_fm1 = 0, b_ep1 = 0, b_wr = 0, b_rd = 0;
   logic [15:0] b_din = '0, b_dout;
   logic        b_full, b_empty, b_hi;
   logic [3:0]  b_lvl;

   epfifo_early #(.CAP_BYTES(8), .IS_IN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wide(1'b0), .cfg_full_m1(a_fm1),
      .cfg_empty_p1(a_ep1), .peer_wide(a_peer), .wr_en(a_wr), .wr_data(a_din),
      .rd_en(a_rd), .rd_data(a_dout), .full_flag(a_full), .empty_flag(a_empty),
      .level(a_lvl), .hi_lane_en(a_hi));

   epfifo_early #(.CAP_BYTES(8), .IS_IN(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .cfg_wide(1'b1), .cfg_full_m1(b_fm1),
      .cfg_empty_p1(b_ep1), .peer_wide(3'b000), .wr_en(b_wr), .wr_data(b_din),
      .rd_en(b_rd), .rd_data(b_dout), .full_flag(b_full), .empty_flag(b_empty),
      .level(b_lvl), .hi_lane_en(b_hi));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // {wr, rd, fm1, din[7:0], full, empty, lvl[3:0], chk_front, front[7:0]}
   localparam int NV = 23;
   localparam logic [25:0] TBL [NV] = '{
      {3'b100, 8'h11, 2'b00, 4'd1, 1'b1, 8'h11},
      {3'b100, 8'h12, 2'b00, 4'd2, 1'b1, 8'h11},
      {3'b100, 8'h13, 2'b00, 4'd3, 1'b1, 8'h11},
      {3'b100, 8'h14, 2'b00, 4'd4, 1'b1, 8'h11},
      {3'b100, 8'h15, 2'b00, 4'd5, 1'b1, 8'h11},
      {3'b100, 8'h16, 2'b00, 4'd6, 1'b1, 8'h11},
      {3'b100, 8'h17, 2'b00, 4'd7, 1'b1, 8'h11},
      {3'b100, 8'h18, 2'b10, 4'd8, 1'b1, 8'h11},
      {3'b100, 8'h19, 2'b10, 4'd8, 1'b1, 8'h11},
      {3'b110, 8'h1A, 2'b00, 4'd7, 1'b1, 8'h12},
      {3'b010, 8'h00, 2'b00, 4'd6, 1'b1, 8'h13},
      {3'b110, 8'h1B, 2'b00, 4'd6, 1'b1, 8'h14},
      {3'b101, 8'h1C, 2'b10, 4'd7, 1'b1, 8'h14},
      {3'b101, 8'h1D, 2'b10, 4'd8, 1'b1, 8'h14},
      {3'b011, 8'h00, 2'b10, 4'd7, 1'b1, 8'h15},
      {3'b010, 8'h00, 2'b00, 4'd6, 1'b1, 8'h16},
      {3'b010, 8'h00, 2'b00, 4'd5, 1'b1, 8'h17},
      {3'b010, 8'h00, 2'b00, 4'd4, 1'b1, 8'h18},
      {3'b010, 8'h00, 2'b00, 4'd3, 1'b1, 8'h1B},
      {3'b010, 8'h00, 2'b00, 4'd2, 1'b1, 8'h1C},
      {3'b010, 8'h00, 2'b00, 4'd1, 1'b1, 8'h1D},
      {3'b010, 8'h00, 2'b01, 4'd0, 1'b0, 8'h00},
      {3'b010, 8'h00, 2'b01, 4'd0, 1'b0, 8'h00}
   };

   task automatic b_step(input logic wr, input logic rd, input logic [15:0] d);
      b_wr = wr; b_rd = rd; b_din = d;
      @(posedge clk); #2;
      b_wr = 0; b_rd = 0;
   endtask

   task automatic b_chk(input string tag, input logic f, input logic e,
                        input logic [3:0] l, input logic [15:0] front, input bit cf);
      check({tag, " full"},  32'(b_full),  32'(f));
      check({tag, " empty"}, 32'(b_empty), 32'(e));
      check({tag, " level"}, 32'(b_lvl),   32'(l));
      if (cf) check({tag, " data"}, 32'(b_dout), 32'(front));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      check("R1 u0 empty", 32'(a_empty), 32'd1);
      check("R1 u0 full",  32'(a_full),  32'd0);
      check("R1 u0 level", 32'(a_lvl),   32'd0);
      check("R1 u1 empty", 32'(b_empty), 32'd1);
      rst_n = 1'b1;
      @(posedge clk); #2;

      // R2 R3 R4 R5 R6 R11: vector walk on the IN byte FIFO
      for (int i = 0; i < NV; i++) begin
         logic [25:0] v;
         v = TBL[i];
         a_wr = v[25]; a_rd = v[24]; a_fm1 = v[23]; a_din = {8'h00, v[22:15]};
         @(posedge clk); #2;
         a_wr = 0; a_rd = 0;
         check($sformatf("R4/R6 full v%0d", i),  32'(a_full),  32'(v[14]));
         check($sformatf("R5 empty v%0d", i),    32'(a_empty), 32'(v[13]));
         check($sformatf("R3 level v%0d", i),    32'(a_lvl),   32'(v[12:9]));
         if (v[8]) check($sformatf("R2 data v%0d", i), 32'(a_dout), {24'h0, v[7:0]});
      end
      a_fm1 = 0;

      // R8: early empty has no effect on the IN instance
      a_ep1 = 1; a_wr = 1; a_din = 16'h00AA;
      @(posedge clk); #2;
      a_wr = 0;
      check("R8 u0 empty at one entry", 32'(a_empty), 32'd0);
      check("R8 u0 level", 32'(a_lvl), 32'd1);
      a_rd = 1;
      @(posedge clk); #2;
      a_rd = 0; a_ep1 = 0;
      check("R8 u0 drained", 32'(a_empty), 32'd1);

      // R10 upper lane
      check("R10 u0 idle lane", 32'(a_hi), 32'd0);
      a_peer = 3'b010; #1;
      check("R10 u0 peer lane", 32'(a_hi), 32'd1);
      a_peer = 3'b000; #1;
      check("R10 u1 own lane", 32'(b_hi), 32'd1);

      // R7 R8 R9 on the OUT 16-bit FIFO (4 entries)
      b_ep1 = 1; b_fm1 = 1;
      b_step(1, 0, 16'hA1B2); b_chk("R7 early empty", 0, 1, 1, 16'hA1B2, 1);
      b_step(1, 0, 16'hC3D4); b_chk("R9 two words",   0, 0, 2, 16'hA1B2, 1);
      b_step(1, 0, 16'hE5F6); b_chk("R8 no early full on OUT", 0, 0, 3, 16'hA1B2, 1);
      b_step(1, 0, 16'h0718); b_chk("R9 word capacity", 1, 0, 4, 16'hA1B2, 1);
      b_step(1, 0, 16'h9999); b_chk("R4 wide drop",   1, 0, 4, 16'hA1B2, 1);
      b_step(0, 1, 16'h0);    b_chk("R9 pop1",        0, 0, 3, 16'hC3D4, 1);
      b_step(0, 1, 16'h0);    b_chk("R9 pop2",        0, 0, 2, 16'hE5F6, 1);
      b_step(0, 1, 16'h0);    b_chk("R7 early at one", 0, 1, 1, 16'h0718, 1);
      b_step(0, 1, 16'h0);    b_chk("R7 read at one accepted", 0, 1, 0, 16'h0, 0);
      b_ep1 = 0;
      b_step(1, 0, 16'h1234); b_chk("R7 true empty mode", 0, 0, 1, 16'h1234, 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule